// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Unit

This block sits between decode and the two integer execute pipes of an in-order, two-wide core. Each cycle it sees up to two decoded instructions in program order (lane 0 is the older, lane 1 the younger). Each carries a class code, two source register indices, a destination index with a write enable, and a register count for load/store-multiple. The block decides in the same cycle which of them may issue and into which pipe (0 or 1) each one goes. It raises a stall when a valid instruction is held back.

The decision rests on three things. The first is fixed per class: which issue slot and which pipe a class may use, and whether it fills both issue slots. The second is the execute-stage occupancy left over from earlier multi-cycle instructions, counted per pipe. The third is a small scoreboard. It keeps a consumer away from a long-latency producer issued in the previous cycle and from its older neighbour in the same cycle. The multiplier speed grade is a static input, captured while reset is asserted.

Top module: `dual_issue_steer`

## Requirements
- R1: Out of reset both pipes are idle and no producer is pending. A lone plain ALU instruction (class 0) in lane 0 is then granted into pipe 0, because pipe 0 is preferred whenever the class allows both pipes.
- R2: Class codes bind pipes. Codes 0 plain ALU, 1 shifted ALU, 2 absolute-difference sum, 3 system/miscellaneous, 4 DSP ALU and 5 paired move, plus the unused codes 24 to 31, may use either pipe. Codes 6 load, 7 post-increment load, 8 store, 9 register-offset store, 10 load-multiple and 11 store-multiple use only pipe 1. Codes 12 multiply, 13 multiply-accumulate, 14 divide, 15 divide-with-remainder, 16 branch, 17 simple DSP (compare, clip, pack, byte insert), 18 DSP rounding, 19 DSP multiply, 20 bit-pick, 21 64-bit DSP ALU, 22 DSP multiply-accumulate and 23 word-extract use only pipe 0.
- R3: Classes 7, 9, 13, 15, 21, 22 and 23 fill both issue slots, so they never issue beside another instruction. Two instructions that both need issue slot 1 (classes 5, 6, 8, 10, 11) never pair. Two that both need issue slot 0 (classes 12, 14, 16 to 20) never pair.
- R4: Issue is in order. Lane 1 is granted only in a cycle where lane 0 is also granted.
- R5: Two instructions granted together go to different pipes. They pair whenever the class rules, idle pipes and hazards allow any assignment; if both assignments work, the older one takes pipe 0.
- R6: An instruction with execute occupancy N keeps its pipe closed to new grants for the next N-1 cycles. N is 2 for class 1, 3 for class 2, 4 for classes 14 and 15, and 1 for every class not named in R6, R7 or R8.
- R7: Load-multiple and store-multiple occupy their pipe for min(count, 4) cycles; a count of 0 is taken as 1.
- R8: Multiply and multiply-accumulate occupy pipe 0 for 1, 2 or 4 cycles when the multiplier setting is 0, 1 or 2/3. The setting is taken only while reset is high, and later changes have no effect.
- R9: After a granted instruction of class 6, 7, 10, 12, 13, 14, 15, 18, 19, 20, 21, 22 or 23 with its write enable set, no instruction reading that destination (either source) is granted in the next cycle. Two cycles after the producer it may be granted.
- R10: For load-multiple the destination field names the last register loaded, and that register obeys the R9 spacing.
- R11: A younger instruction that reads the older lane's written destination is not granted in the same cycle as the older one.
- R12: The stall output is high exactly when some valid lane is not granted.
- R13: Results of classes not listed in R9 do not hold a dependent instruction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; multiplier setting captured while high |
| mul_cfg | input | 2 | Multiplier speed grade: 0 one cycle, 1 two cycles, 2 or 3 four cycles |
| in_vld | input | 2 | Lane valid, bit 0 older lane |
| in_cls | input | 2x5 | Class code per lane |
| in_rs1 | input | 2xRW | First source register per lane |
| in_rs2 | input | 2xRW | Second source register per lane |
| in_rd | input | 2xRW | Destination register per lane (last loaded register for load-multiple) |
| in_rd_we | input | 2 | Destination write enable per lane |
| in_lsm_cnt | input | 2x4 | Register count for load/store-multiple |
| out_grant | output | 2 | Issue grant per lane |
| out_pipe | output | 2 | Chosen pipe per lane, valid where granted |
| out_stall | output | 1 | High when a valid lane is held |

## Verification
A wrong occupancy count shows up at the grant output in the cycle after the multi-cycle instruction issues: a pipe is reopened too early or held too long. A corrupted or missing scoreboard entry shows as a dependent consumer granted or refused one cycle after its producer. Since grants are combinational from that state, every such fault reaches the ports in the same cycle it would affect issue. Random mixes of classes with a narrow register range make these collisions frequent; directed sequences then pin each occupancy length and each spacing edge.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int LANES = 2;
    localparam int NPIPE = 2;
    localparam int CLS_W = 5;
    localparam int CNT_W = 4;
    localparam int OCC_W = 3;
    localparam int LSM_MAX = 4;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU     = 5'd0,
        CL_SHIFT   = 5'd1,
        CL_SAD     = 5'd2,
        CL_SYS     = 5'd3,
        CL_DALU    = 5'd4,
        CL_MOVPAIR = 5'd5,
        CL_LD      = 5'd6,
        CL_LD_PI   = 5'd7,
        CL_ST      = 5'd8,
        CL_ST_RO   = 5'd9,
        CL_LDM     = 5'd10,
        CL_STM     = 5'd11,
        CL_MUL     = 5'd12,
        CL_MAC     = 5'd13,
        CL_DIV     = 5'd14,
        CL_DIVMOD  = 5'd15,
        CL_BR      = 5'd16,
        CL_DSPS    = 5'd17,
        CL_DRND    = 5'd18,
        CL_DMUL    = 5'd19,
        CL_DBPICK  = 5'd20,
        CL_DALU64  = 5'd21,
        CL_DMAC    = 5'd22,
        CL_WEXT    = 5'd23
    } cls_e;

    // Issue behaviour of one decoded instruction.
    typedef struct packed {
        logic             dual;      // fills both issue slots
        logic [1:0]       slots;     // bit k: may use issue slot k
        logic [1:0]       pipes;     // bit k: may execute in pipe k
        logic [OCC_W-1:0] occ;       // execute-stage cycles
        logic             long_lat;  // result forwardable from memory stage only
    } cls_attr_t;

    function automatic logic [OCC_W-1:0] mul_occ(input logic [1:0] cfg);
        case (cfg)
            2'd0:    return OCC_W'(1);
            2'd1:    return OCC_W'(2);
            default: return OCC_W'(4);
        endcase
    endfunction

    function automatic logic [OCC_W-1:0] lsm_occ(input logic [CNT_W-1:0] n);
        if (n == '0)
            return OCC_W'(1);
        if (n >= CNT_W'(LSM_MAX))
            return OCC_W'(LSM_MAX);
        return OCC_W'(n);
    endfunction

    function automatic cls_attr_t decode_cls(input logic [CLS_W-1:0] c,
                                             input logic [OCC_W-1:0] mocc,
                                             input logic [CNT_W-1:0] cnt);
        cls_attr_t a;
        a.dual     = 1'b0;
        a.slots    = 2'b11;
        a.pipes    = 2'b11;
        a.occ      = OCC_W'(1);
        a.long_lat = 1'b0;
        case (c)
            CL_SHIFT:   a.occ = OCC_W'(2);
            CL_SAD:     a.occ = OCC_W'(3);
            CL_MOVPAIR: a.slots = 2'b10;
            CL_LD: begin
                a.slots = 2'b10; a.pipes = 2'b10; a.long_lat = 1'b1;
            end
            CL_LD_PI: begin
                a.dual = 1'b1; a.pipes = 2'b10; a.long_lat = 1'b1;
            end
            CL_ST: begin
                a.slots = 2'b10; a.pipes = 2'b10;
            end
            CL_ST_RO: begin
                a.dual = 1'b1; a.pipes = 2'b10;
            end
            CL_LDM: begin
                a.slots = 2'b10; a.pipes = 2'b10; a.occ = lsm_occ(cnt); a.long_lat = 1'b1;
            end
            CL_STM: begin
                a.slots = 2'b10; a.pipes = 2'b10; a.occ = lsm_occ(cnt);
            end
            CL_MUL: begin
                a.slots = 2'b01; a.pipes = 2'b01; a.occ = mocc; a.long_lat = 1'b1;
            end
            CL_MAC: begin
                a.dual = 1'b1; a.pipes = 2'b01; a.occ = mocc; a.long_lat = 1'b1;
            end
            CL_DIV: begin
                a.slots = 2'b01; a.pipes = 2'b01; a.occ = OCC_W'(4); a.long_lat = 1'b1;
            end
            CL_DIVMOD: begin
                a.dual = 1'b1; a.pipes = 2'b01; a.occ = OCC_W'(4); a.long_lat = 1'b1;
            end
            CL_BR, CL_DSPS: begin
                a.slots = 2'b01; a.pipes = 2'b01;
            end
            CL_DRND, CL_DMUL, CL_DBPICK: begin
                a.slots = 2'b01; a.pipes = 2'b01; a.long_lat = 1'b1;
            end
            CL_DALU64, CL_DMAC, CL_WEXT: begin
                a.dual = 1'b1; a.pipes = 2'b01; a.long_lat = 1'b1;
            end
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/steer_occupancy.sv
module steer_occupancy
    import steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OCC_W-1:0] load_occ,
    output logic             busy
);

    logic [OCC_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (load)
            remain_q <= load_occ - OCC_W'(1);
        else if (remain_q != '0)
            remain_q <= remain_q - OCC_W'(1);
    end

    assign busy = (remain_q != '0);

    // R6: a new instruction enters only an idle execute stage
    a_r6_free_on_load: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

    // R6: a multi-cycle occupant closes the pipe in the following cycle
    a_r6_hold_after_multi: assert property (@(posedge clk) disable iff (rst)
        (load && load_occ > OCC_W'(1)) |=> busy);

endmodule

// File: rtl/steer_scoreboard.sv
module steer_scoreboard
    import steer_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES-1:0]          iss,
    input  logic [LANES-1:0]          we,
    input  logic [LANES-1:0]          long_lat,
    input  logic [LANES-1:0][RW-1:0]  rs1,
    input  logic [LANES-1:0][RW-1:0]  rs2,
    input  logic [LANES-1:0][RW-1:0]  rd,
    output logic [LANES-1:0]          haz,
    output logic                      raw
);

    logic [LANES-1:0]         pend_v_q;
    logic [LANES-1:0][RW-1:0] pend_rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q  <= '0;
            pend_rd_q <= '0;
        end else begin
            pend_v_q  <= iss & we & long_lat;
            pend_rd_q <= rd;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANES-1:0] hit;
        for (genvar j = 0; j < LANES; j++) begin : g_src
            assign hit[j] = pend_v_q[j] &&
                            (rs1[i] == pend_rd_q[j] || rs2[i] == pend_rd_q[j]);

            // R9: a consumer never issues one cycle after its long-latency producer
            a_r9_spacing: assert property (@(posedge clk) disable iff (rst)
                (iss[j] && we[j] && long_lat[j]) |=>
                !(iss[i] && (rs1[i] == $past(rd[j]) || rs2[i] == $past(rd[j]))));
        end
        assign haz[i] = |hit;
    end

    assign raw = we[0] && (rs1[1] == rd[0] || rs2[1] == rd[0]);

    // R11: the younger lane never issues beside the producer of its operand
    a_r11_no_same_cycle_raw: assert property (@(posedge clk) disable iff (rst)
        iss[1] |-> !(we[0] && (rs1[1] == rd[0] || rs2[1] == rd[0])));

endmodule

// File: rtl/steer_arbiter.sv
module steer_arbiter
    import steer_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            vld,
    input  cls_attr_t [LANES-1:0]       attr,
    input  logic [LANES-1:0]            haz,
    input  logic                        raw,
    input  logic [NPIPE-1:0]            busy,
    output logic [LANES-1:0]            grant,
    output logic [LANES-1:0]            pipe
);

    logic [NPIPE-1:0] free;
    logic             can_old;
    logic             slot_ok;
    logic             fit_a;     // older pipe 0, younger pipe 1
    logic             fit_b;     // older pipe 1, younger pipe 0
    logic             pair;

    always_comb begin
        free    = ~busy;
        can_old = vld[0] && !haz[0] && |(attr[0].pipes & free);
        slot_ok = !attr[0].dual && !attr[1].dual &&
                  !((attr[0].slots == attr[1].slots) && (attr[0].slots != 2'b11));
        fit_a   = attr[0].pipes[0] && free[0] && attr[1].pipes[1] && free[1];
        fit_b   = attr[0].pipes[1] && free[1] && attr[1].pipes[0] && free[0];
        pair    = can_old && vld[1] && !haz[1] && !raw && slot_ok && (fit_a || fit_b);
        grant   = {pair, can_old};
        if (pair) begin
            pipe[0] = !fit_a;
            pipe[1] = fit_a;
        end else begin
            pipe[0] = !(attr[0].pipes[0] && free[0]);
            pipe[1] = 1'b0;
        end
    end

    // R4: in-order issue
    a_r4_in_order: assert property (@(posedge clk) disable iff (rst)
        grant[1] |-> grant[0]);

    // R5: paired instructions go to different pipes
    a_r5_distinct_pipes: assert property (@(posedge clk) disable iff (rst)
        (&grant) |-> (pipe[0] != pipe[1]));

    // R3: a two-slot class issues alone
    a_r3_dual_alone: assert property (@(posedge clk) disable iff (rst)
        (grant[0] && attr[0].dual) |-> !grant[1]);

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R2: the chosen pipe is one the class allows
        a_r2_pipe_allowed: assert property (@(posedge clk) disable iff (rst)
            grant[l] |-> attr[l].pipes[pipe[l]]);
    end

endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
    import steer_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  mul_cfg,
    input  logic [1:0]                  in_vld,
    input  logic [1:0][CLS_W-1:0]       in_cls,
    input  logic [1:0][RW-1:0]          in_rs1,
    input  logic [1:0][RW-1:0]          in_rs2,
    input  logic [1:0][RW-1:0]          in_rd,
    input  logic [1:0]                  in_rd_we,
    input  logic [1:0][CNT_W-1:0]       in_lsm_cnt,
    output logic [1:0]                  out_grant,
    output logic [1:0]                  out_pipe,
    output logic                        out_stall
);

    logic [OCC_W-1:0]            mul_occ_q;
    cls_attr_t [LANES-1:0]       attr;
    logic [LANES-1:0]            haz;
    logic                        raw;
    logic [NPIPE-1:0]            busy;
    logic [LANES-1:0]            grant;
    logic [LANES-1:0]            pipe_sel;
    logic [LANES-1:0]            long_lat;
    logic [NPIPE-1:0]            pipe_load;
    logic [NPIPE-1:0][OCC_W-1:0] pipe_occ;

    // Multiplier grade is static: captured only while reset is held.
    always_ff @(posedge clk) begin
        if (rst)
            mul_occ_q <= mul_occ(mul_cfg);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_dec
        assign attr[l]     = decode_cls(in_cls[l], mul_occ_q, in_lsm_cnt[l]);
        assign long_lat[l] = attr[l].long_lat;
    end

    steer_scoreboard #(.RW(RW)) u_sb (
        .clk      (clk),
        .rst      (rst),
        .iss      (grant),
        .we       (in_rd_we),
        .long_lat (long_lat),
        .rs1      (in_rs1),
        .rs2      (in_rs2),
        .rd       (in_rd),
        .haz      (haz),
        .raw      (raw)
    );

    steer_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .vld   (in_vld),
        .attr  (attr),
        .haz   (haz),
        .raw   (raw),
        .busy  (busy),
        .grant (grant),
        .pipe  (pipe_sel)
    );

    always_comb begin
        pipe_load = '0;
        pipe_occ  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (grant[l]) begin
                pipe_load[pipe_sel[l]] = 1'b1;
                pipe_occ[pipe_sel[l]]  = attr[l].occ;
            end
        end
    end

    for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
        steer_occupancy u_occ (
            .clk      (clk),
            .rst      (rst),
            .load     (pipe_load[p]),
            .load_occ (pipe_occ[p]),
            .busy     (busy[p])
        );
    end

    assign out_grant = grant;
    assign out_pipe  = pipe_sel;
    assign out_stall = |(in_vld & ~grant);

    // R12: nothing granted without a valid instruction behind it
    a_r12_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        |(out_grant & ~in_vld) == 1'b0);

endmodule

// File: tb/dual_issue_steer_bench.sv
`timescale 1ns/1ps
module dual_issue_steer_bench;

    localparam int RW = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           mul_cfg = 2'd0;
    logic [1:0]           vld = '0;
    logic [1:0][4:0]      cls = '0;
    logic [1:0][RW-1:0]   rs1 = '0, rs2 = '0, rd = '0;
    logic [1:0]           we = '0;
    logic [1:0][3:0]      cnt = '0;
    logic [1:0]           grant, pipe;
    logic                 stall;

    always #2 clk = ~clk;

    dual_issue_steer #(.RW(RW)) u_dual_issue_steer (
        .clk(clk), .rst(rst), .mul_cfg(mul_cfg),
        .in_vld(vld), .in_cls(cls), .in_rs1(rs1), .in_rs2(rs2), .in_rd(rd),
        .in_rd_we(we), .in_lsm_cnt(cnt),
        .out_grant(grant), .out_pipe(pipe), .out_stall(stall)
    );

    int n_vec = 0, n_bad = 0;
    int m_busy[2];
    bit m_pv[2];
    int m_prd[2];
    int m_mocc = 1;
    bit finished = 1'b0;

    function automatic int b_pm(int c);
        if (c >= 6 && c <= 11) return 2;
        if (c >= 12 && c <= 23) return 1;
        return 3;
    endfunction

    function automatic bit b_dual(int c);
        return c == 7 || c == 9 || c == 13 || c == 15 || c == 21 || c == 22 || c == 23;
    endfunction

    function automatic int b_sm(int c);
        if (c == 5 || c == 6 || c == 8 || c == 10 || c == 11) return 2;
        if (c == 12 || c == 14 || (c >= 16 && c <= 20)) return 1;
        return 3;
    endfunction

    function automatic bit b_long(int c);
        return c == 6 || c == 7 || c == 10 || (c >= 12 && c <= 15) || (c >= 18 && c <= 23);
    endfunction

    function automatic int b_occ(int c, int n);
        if (c == 1) return 2;
        if (c == 2) return 3;
        if (c == 10 || c == 11) return (n == 0) ? 1 : ((n > 4) ? 4 : n);
        if (c == 12 || c == 13) return m_mocc;
        if (c == 14 || c == 15) return 4;
        return 1;
    endfunction

    task automatic model(output logic [1:0] eg, output logic [1:0] ep);
        bit fr[2]; bit h[2]; bit rw; int pm[2]; int sm[2]; bit du[2];
        for (int k = 0; k < 2; k++) fr[k] = (m_busy[k] == 0);
        for (int i = 0; i < 2; i++) begin
            pm[i] = b_pm(int'(cls[i]));
            sm[i] = b_sm(int'(cls[i]));
            du[i] = b_dual(int'(cls[i]));
            h[i]  = 1'b0;
            for (int j = 0; j < 2; j++)
                if (m_pv[j] && (int'(rs1[i]) == m_prd[j] || int'(rs2[i]) == m_prd[j])) h[i] = 1'b1;
        end
        rw = we[0] && (rs1[1] == rd[0] || rs2[1] == rd[0]);
        eg = '0; ep = '0;
        if (vld[0] && !h[0]) begin
            for (int k = 1; k >= 0; k--)
                if (pm[0][k] && fr[k]) begin eg[0] = 1'b1; ep[0] = k[0]; end
            if (eg[0] && vld[1] && !h[1] && !rw && !du[0] && !du[1] &&
                !(sm[0] == sm[1] && sm[0] != 3))
                for (int k = 1; k >= 0; k--)
                    if (pm[0][k] && fr[k] && pm[1][1-k] && fr[1-k]) begin
                        eg[1] = 1'b1; ep[0] = k[0]; ep[1] = ~k[0];
                    end
        end
    endtask

    task automatic advance(input logic [1:0] eg, input logic [1:0] ep);
        for (int k = 0; k < 2; k++) if (m_busy[k] > 0) m_busy[k]--;
        for (int i = 0; i < 2; i++)
            if (eg[i]) m_busy[ep[i]] = b_occ(int'(cls[i]), int'(cnt[i])) - 1;
        for (int i = 0; i < 2; i++) begin
            m_pv[i]  = eg[i] && we[i] && b_long(int'(cls[i]));
            m_prd[i] = int'(rd[i]);
        end
    endtask

    task automatic step(input string tag);
        logic [1:0] eg, ep; logic es;
        #1;
        model(eg, ep);
        es = |(vld & ~eg);
        n_vec++;
        if (grant !== eg || ((pipe ^ ep) & eg) != 2'b00 || stall !== es) begin
            n_bad++;
            $display("FAIL %s: grant=%b pipe=%b stall=%b expected grant=%b pipe=%b stall=%b",
                     tag, grant, pipe, stall, eg, ep, es);
        end
        advance(eg, ep);
        @(negedge clk);
    endtask

    task automatic put(input int l, input int c, input int a, input int b,
                       input int d, input bit w, input int n);
        vld[l] = 1'b1; cls[l] = 5'(c); rs1[l] = RW'(a); rs2[l] = RW'(b);
        rd[l] = RW'(d); we[l] = w; cnt[l] = 4'(n);
    endtask

    task automatic clear();
        vld = '0; cls = '0; rs1 = '0; rs2 = '0; rd = '0; we = '0; cnt = '0;
    endtask

    task automatic do_reset(input int cfg);
        @(negedge clk);
        rst = 1'b1; mul_cfg = 2'(cfg); clear();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_mocc = (cfg == 0) ? 1 : ((cfg == 1) ? 2 : 4);
        for (int k = 0; k < 2; k++) begin m_busy[k] = 0; m_pv[k] = 1'b0; m_prd[k] = 0; end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): run=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7391));
        do_reset(0);
        clear(); step("R12 idle after reset");
        put(0, 0, 1, 2, 3, 0, 0); step("R1 lone alu prefers pipe 0");
        // R2 pipe binding
        clear(); put(0, 6, 1, 2, 3, 0, 0); step("R2 load pipe 1");
        clear(); put(0, 12, 1, 2, 3, 0, 0); step("R2 mul pipe 0");
        // R5 pairing
        clear(); put(0, 0, 1, 2, 3, 0, 0); put(1, 6, 1, 2, 4, 0, 0); step("R5 alu+load pair");
        clear(); put(0, 6, 1, 2, 3, 0, 0); put(1, 0, 1, 2, 4, 0, 0); step("R5 load+alu pair");
        clear(); put(0, 5, 1, 2, 3, 0, 0); put(1, 12, 1, 2, 4, 0, 0); step("R5 movpair+mul pair");
        // R3 slot rules
        clear(); put(0, 6, 1, 2, 3, 0, 0); put(1, 8, 1, 2, 4, 0, 0); step("R3 two slot-1 classes");
        clear(); put(0, 12, 1, 2, 3, 0, 0); put(1, 16, 1, 2, 4, 0, 0); step("R3 two slot-0 classes");
        clear(); put(0, 13, 1, 2, 3, 0, 0); put(1, 0, 1, 2, 4, 0, 0); step("R3 dual older alone");
        clear(); put(0, 0, 1, 2, 3, 0, 0); put(1, 7, 1, 2, 4, 0, 0); step("R3 dual younger waits");
        // R6 occupancy
        clear(); put(0, 1, 1, 2, 3, 0, 0); step("R6 shift issue");
        put(0, 0, 1, 2, 3, 0, 0); put(1, 0, 1, 2, 4, 0, 0); step("R6 shift holds pipe 0");
        step("R6 shift released");
        clear(); put(0, 14, 1, 2, 3, 0, 0); step("R6 div issue");
        clear(); put(0, 12, 1, 2, 3, 0, 0);
        repeat (3) step("R6 div holds pipe 0");
        step("R6 div released");
        clear(); put(0, 2, 1, 2, 3, 0, 0); step("R6 sad issue");
        clear(); put(0, 16, 1, 2, 3, 0, 0);
        repeat (3) step("R6 sad hold and release");
        // R4 in-order hold
        clear(); put(0, 14, 1, 2, 3, 0, 0); step("R4 div issue");
        clear(); put(0, 12, 1, 2, 3, 0, 0); put(1, 6, 1, 2, 4, 0, 0); step("R4 younger held behind older");
        clear(); repeat (3) step("R4 drain");
        // R7 load/store-multiple
        clear(); put(0, 10, 1, 2, 3, 0, 7); step("R7 ldm count 7");
        clear(); put(0, 6, 1, 2, 3, 0, 0);
        repeat (3) step("R7 ldm holds pipe 1");
        step("R7 ldm released");
        clear(); put(0, 11, 1, 2, 3, 0, 0); step("R7 stm count 0");
        clear(); put(0, 8, 1, 2, 3, 0, 0); step("R7 count 0 is one cycle");
        clear(); put(0, 11, 1, 2, 3, 0, 3); step("R7 stm count 3");
        clear(); put(0, 8, 1, 2, 3, 0, 0); repeat (3) step("R7 stm count 3 hold and release");
        // R9 long-latency spacing
        clear(); put(0, 6, 1, 2, 5, 1, 0); step("R9 load producer");
        clear(); put(0, 0, 5, 0, 7, 0, 0); step("R9 consumer held");
        step("R9 consumer granted two cycles later");
        clear(); put(0, 12, 1, 2, 6, 1, 0); step("R9 mul producer");
        clear(); put(0, 0, 0, 6, 7, 0, 0); put(1, 6, 1, 2, 4, 0, 0); step("R9 second source held");
        step("R9 second source granted");
        // R10 last register of load-multiple
        clear(); put(0, 10, 1, 2, 9, 1, 1); step("R10 ldm producer");
        clear(); put(0, 0, 9, 0, 7, 0, 0); step("R10 last register held");
        step("R10 last register granted");
        // R11 same-cycle dependency
        clear(); put(0, 0, 1, 2, 3, 1, 0); put(1, 0, 3, 2, 4, 0, 0); step("R11 younger reads older");
        // R13 short result
        clear(); put(0, 0, 1, 2, 4, 1, 0); step("R13 alu producer");
        clear(); put(0, 0, 4, 4, 7, 0, 0); step("R13 consumer next cycle");
        // R8 multiplier grade
        do_reset(2); mul_cfg = 2'd0;
        clear(); put(0, 12, 1, 2, 3, 0, 0); step("R8 slow mul issue");
        repeat (3) step("R8 slow mul holds despite later cfg change");
        step("R8 slow mul released");
        do_reset(1);
        clear(); put(0, 13, 1, 2, 3, 0, 0); step("R8 fast2 mac issue");
        clear(); put(0, 12, 1, 2, 3, 0, 0); step("R8 fast2 holds one cycle");
        step("R8 fast2 released");
        do_reset(0);
        clear(); put(0, 12, 1, 2, 3, 0, 0); step("R8 fast1 issue");
        step("R8 fast1 next cycle");
        // Random mixes
        for (int it = 0; it < 4000; it++) begin
            if (it % 800 == 0) do_reset(int'($urandom % 4));
            for (int l = 0; l < 2; l++) begin
                put(l, int'($urandom % 32), int'($urandom % 6), int'($urandom % 6),
                    int'($urandom % 6), bit'($urandom % 2), int'($urandom % 16));
                vld[l] = ($urandom % 8) != 0;
            end
            step("R5 R12 random mix");
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule